// File: doc/BRIEF.md
# I2C Slave Engine with Host Status Flags

This block is an I2C target that runs from a fast system clock. It oversamples the open-drain SCL and SDA lines, finds Start and Stop conditions, and shifts bytes in and out. A host beside it reads and writes a small set of strobes and flags. The host programs the address register and reads received bytes from a single buffer. When the bus master reads, the host loads that same buffer with the bytes to send. The hardware sets a sticky interrupt flag after every byte that concerns this target. The host clears that flag.

The engine answers 7-bit or 10-bit addresses, chosen by a configuration input. In 10-bit mode the comparator holds one byte at a time. After each address byte the engine holds SCL low and raises an update-address flag. The host then writes the next value to compare against: the low byte after the high byte, and the high byte again after the low byte. For a read, the engine holds SCL low after the address, and again after each byte the master acknowledges. It waits each time until the host loads data and releases the clock. The engine drives neither line high. It only produces pull-low enables.

Top module: `i2cs_slave`

## Requirements
- R1: After a synchronous reset the buffer, all status flags and both pull-low enables are 0.
- R2: With 10-bit mode off, bits are sampled MSB first on rising SCL after a Start. The address byte matches when its bits 7:1 equal bits 7:1 of the address register, and bit 0 is the read flag (1 = read). A mismatch gives no ACK and sets no flag.
- R3: A matched address or data byte that arrives while the full and overflow flags are both clear is copied into the buffer. It sets the full flag, gets an ACK (SDA low) in the ninth clock, and sets the interrupt flag after the ninth falling SCL edge.
- R4: A matched byte that arrives while the full or the overflow flag is set gets no ACK and leaves the buffer unchanged, but it still sets the interrupt flag. If the full flag was set, the overflow flag is also set.
- R5: A buffer read strobe clears the full flag. The overflow flag is cleared only by its clear strobe, and the interrupt flag only by its own clear strobe.
- R6: With 10-bit mode on, the first address byte matches when it is 11110,A9,A8,0 and its bits 7:1 equal the address register bits 7:1. The second byte matches when all 8 bits equal the address register. After each matched address byte the update-address flag is set and SCL is held low. An address write clears the flag and releases SCL.
- R7: In 10-bit mode, a high address byte with the read flag set is accepted only after both address bytes have matched since the last Stop. The engine then becomes a transmitter. A Stop returns the engine to idle and discards that progress.
- R8: A matched read address sets the read status bit, is ACKed, and then SCL is held low. A buffer write also loads the transmit shifter. SCL is released only by the release strobe, and that strobe is ignored while the update-address flag is set.
- R9: Transmit data leaves MSB first. SDA changes only while SCL is low. After a master ACK, the interrupt flag is set and SCL is held low again.
- R10: A master NACK after a transmitted byte ends the transfer. Both pull-low enables return to 0 until the next Start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| ten_bit_en | input | 1 | 1 selects 10-bit addressing |
| host_wdata | input | 8 | Data for address and buffer writes |
| host_wr_addr | input | 1 | Strobe: load address register, clear update-address flag |
| host_wr_buf | input | 1 | Strobe: load buffer and transmit shifter |
| host_rd_buf | input | 1 | Strobe: buffer has been read, clear full flag |
| host_rel_scl | input | 1 | Strobe: release a held SCL |
| host_clr_ovf | input | 1 | Strobe: clear overflow flag |
| host_clr_irq | input | 1 | Strobe: clear interrupt flag |
| buf_data | output | 8 | Buffer contents |
| stat_full | output | 1 | Buffer holds an unread byte |
| stat_ovf | output | 1 | Byte arrived while buffer was full |
| stat_upd_addr | output | 1 | Host must rewrite the address register |
| stat_rw | output | 1 | Read flag of the last matched address |
| irq | output | 1 | Sticky interrupt flag |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_pull | output | 1 | Pull SCL low |
| sda_pull | output | 1 | Pull SDA low |

## Verification
The embedded properties check these rules on every cycle: SDA never moves while the synchronized SCL is high, an ACK is only raised into an empty, non-overflowed buffer, the update-address flag always holds the clock, and the overflow and interrupt flags stay set until cleared. Address matching in both modes, the 10-bit rewrite sequence, Repeated Start reads, and the data order on the wire can only be seen in bench scenarios. In those, a bit-level master drives whole transactions and the host plays its part between bytes.

// File: rtl/i2cs_pkg.sv
// Package: shared constants and the engine state type.
// Assumes bytes are eight bits wide, as on any I2C bus.
package i2cs_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);
    localparam logic [4:0] TEN_PREFIX = 5'b11110;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK,
        ST_RX,
        ST_TX,
        ST_TXACK,
        ST_WAIT
    } i2cs_state_e;
endpackage

// File: rtl/i2cs_line_sync.sv
// Line conditioner: brings SCL and SDA into the clock domain and derives
// SCL edges plus Start/Stop events. Assumes SCL is many clocks long, so
// both lines pass through equal-length pipelines and keep their order.
module i2cs_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    logic [STAGES-1:0] scl_p, sda_p;
    logic              scl_d, sda_d;

    // Purpose: multi-flop synchronizers plus one delayed copy for edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_p <= '1;
            sda_p <= '1;
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_p <= {scl_p[STAGES-2:0], scl_in};
            sda_p <= {sda_p[STAGES-2:0], sda_in};
            scl_d <= scl_p[STAGES-1];
            sda_d <= sda_p[STAGES-1];
        end
    end

    // Purpose: edge and bus-condition decode from synchronized levels.
    always_comb begin
        scl_s     = scl_p[STAGES-1];
        sda_s     = sda_p[STAGES-1];
        scl_rise  = scl_s & ~scl_d;
        scl_fall  = ~scl_s & scl_d;
        start_evt = scl_s & scl_d & sda_d & ~sda_s;
        stop_evt  = scl_s & scl_d & ~sda_d & sda_s;
    end
endmodule

// File: rtl/i2cs_core.sv
// Protocol engine and host-visible state: shifts bytes, matches 7/10-bit
// addresses, makes ACK/NACK, loads the buffer, stretches SCL and keeps the
// status flags. Assumes event inputs come from i2cs_line_sync and that the
// host touches the buffer only while SCL is held low.
module i2cs_core
    import i2cs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ten_bit_en,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic [BYTE_W-1:0] host_wdata,
    input  logic              host_wr_addr,
    input  logic              host_wr_buf,
    input  logic              host_rd_buf,
    input  logic              host_rel_scl,
    input  logic              host_clr_ovf,
    input  logic              host_clr_irq,
    output logic [BYTE_W-1:0] buf_q,
    output logic              bf_q,
    output logic              ovf_q,
    output logic              upd_q,
    output logic              rw_q,
    output logic              irq_q,
    output logic              scl_pull,
    output logic              sda_pull
);
    localparam logic [CNT_W-1:0] LAST_RX = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_TX = CNT_W'(BYTE_W - 1);

    i2cs_state_e       state, after;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] sr, tx_sr, addr_q;
    logic              hold_q, ack_drv, go_upd, go_hold;
    logic              low_stage, ten_ok, mack;

    // Address decision inputs derived from the received byte.
    logic              hit, want_upd, want_hold, set_ten, hit_rw;
    i2cs_state_e       hit_to;
    logic              hi_ok;

    // Purpose: decide whether the shifted address byte is ours and what follows.
    always_comb begin
        hit       = 1'b0;
        hit_to    = ST_WAIT;
        want_upd  = 1'b0;
        want_hold = 1'b0;
        set_ten   = 1'b0;
        hit_rw    = sr[0];
        hi_ok     = (sr[BYTE_W-1:BYTE_W-5] == TEN_PREFIX) &&
                    (sr[BYTE_W-1:1] == addr_q[BYTE_W-1:1]);
        if (!ten_bit_en) begin
            hit       = (sr[BYTE_W-1:1] == addr_q[BYTE_W-1:1]);
            hit_to    = sr[0] ? ST_TX : ST_RX;
            want_hold = sr[0];
        end else if (low_stage) begin
            hit      = (sr == addr_q);
            hit_to   = ST_RX;
            want_upd = 1'b1;
            set_ten  = 1'b1;
            hit_rw   = 1'b0;
        end else if (!sr[0]) begin
            hit      = hi_ok;
            hit_to   = ST_ADDR;
            want_upd = 1'b1;
        end else begin
            hit       = hi_ok && ten_ok;
            hit_to    = ST_TX;
            want_hold = 1'b1;
        end
    end

    // Purpose: host strobes first, then bus events, which win on a collision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            after     <= ST_IDLE;
            cnt       <= '0;
            sr        <= '0;
            tx_sr     <= '0;
            addr_q    <= '0;
            buf_q     <= '0;
            bf_q      <= 1'b0;
            ovf_q     <= 1'b0;
            upd_q     <= 1'b0;
            rw_q      <= 1'b0;
            irq_q     <= 1'b0;
            hold_q    <= 1'b0;
            ack_drv   <= 1'b0;
            go_upd    <= 1'b0;
            go_hold   <= 1'b0;
            low_stage <= 1'b0;
            ten_ok    <= 1'b0;
            mack      <= 1'b1;
        end else begin
            if (host_rd_buf)  bf_q  <= 1'b0;
            if (host_clr_ovf) ovf_q <= 1'b0;
            if (host_clr_irq) irq_q <= 1'b0;
            if (host_wr_addr) begin
                addr_q <= host_wdata;
                if (upd_q) begin
                    upd_q  <= 1'b0;
                    hold_q <= 1'b0;
                end
            end
            if (host_wr_buf) begin
                buf_q <= host_wdata;
                tx_sr <= host_wdata;
            end
            if (host_rel_scl && !upd_q) hold_q <= 1'b0;

            if (stop_evt) begin
                state     <= ST_IDLE;
                ack_drv   <= 1'b0;
                ten_ok    <= 1'b0;
                low_stage <= 1'b0;
            end else if (start_evt) begin
                state     <= ST_ADDR;
                cnt       <= '0;
                ack_drv   <= 1'b0;
                low_stage <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_RX: begin
                        if (scl_rise) begin
                            sr  <= {sr[BYTE_W-2:0], sda_s};
                            cnt <= cnt + 1'b1;
                        end else if (scl_fall && cnt == LAST_RX) begin
                            cnt     <= '0;
                            go_upd  <= 1'b0;
                            go_hold <= 1'b0;
                            after   <= ST_RX;
                            state   <= ST_ACK;
                            if (state == ST_ADDR && !hit) begin
                                state <= ST_WAIT;
                            end else if (!bf_q && !ovf_q) begin
                                buf_q   <= sr;
                                bf_q    <= 1'b1;
                                ack_drv <= 1'b1;
                                if (state == ST_ADDR) begin
                                    rw_q      <= hit_rw;
                                    after     <= hit_to;
                                    go_upd    <= want_upd;
                                    go_hold   <= want_hold;
                                    low_stage <= (hit_to == ST_ADDR);
                                    if (set_ten) ten_ok <= 1'b1;
                                end
                            end else begin
                                if (bf_q) ovf_q <= 1'b1;
                                if (state == ST_ADDR) after <= ST_WAIT;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            ack_drv <= 1'b0;
                            irq_q   <= 1'b1;
                            if (go_upd) upd_q <= 1'b1;
                            if (go_upd || go_hold) hold_q <= 1'b1;
                            state <= after;
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            tx_sr <= {tx_sr[BYTE_W-2:0], 1'b0};
                            if (cnt == LAST_TX) begin
                                cnt   <= '0;
                                state <= ST_TXACK;
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end
                    end
                    ST_TXACK: begin
                        if (scl_rise) begin
                            mack <= sda_s;
                        end else if (scl_fall) begin
                            if (!mack) begin
                                irq_q  <= 1'b1;
                                hold_q <= 1'b1;
                                state  <= ST_TX;
                            end else begin
                                state <= ST_WAIT;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Purpose: open-drain enables; the shifter's MSB owns SDA while sending.
    always_comb begin
        scl_pull = hold_q;
        sda_pull = (state == ST_TX) ? ~tx_sr[BYTE_W-1] : ack_drv;
    end

    AST_ACK_NEEDS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_drv) |-> $past(!bf_q && !ovf_q)); // R4
    AST_ACK_FILLS_BUF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_drv) |-> bf_q); // R3
    AST_UPD_HOLDS_SCL: assert property (@(posedge clk) disable iff (!rst_n)
        upd_q |-> scl_pull); // R6
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !host_clr_ovf) |=> ovf_q); // R5
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && !host_clr_irq) |=> irq_q); // R5
    AST_SDA_MOVES_LOW_SCL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull) |-> !scl_s); // R9
endmodule

// File: rtl/i2cs_slave.sv
// Top level: line conditioner feeding the protocol engine. Assumes scl_in
// and sda_in are the resolved open-drain line levels and that the outside
// pulls a line low whenever the matching *_pull output is 1.
module i2cs_slave #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ten_bit_en,
    input  logic [7:0] host_wdata,
    input  logic       host_wr_addr,
    input  logic       host_wr_buf,
    input  logic       host_rd_buf,
    input  logic       host_rel_scl,
    input  logic       host_clr_ovf,
    input  logic       host_clr_irq,
    output logic [7:0] buf_data,
    output logic       stat_full,
    output logic       stat_ovf,
    output logic       stat_upd_addr,
    output logic       stat_rw,
    output logic       irq,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       scl_pull,
    output logic       sda_pull
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;

    i2cs_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_evt(start_evt), .stop_evt(stop_evt)
    );

    i2cs_core core_i (
        .clk(clk), .rst_n(rst_n), .ten_bit_en(ten_bit_en),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_evt(start_evt), .stop_evt(stop_evt),
        .host_wdata(host_wdata), .host_wr_addr(host_wr_addr),
        .host_wr_buf(host_wr_buf), .host_rd_buf(host_rd_buf),
        .host_rel_scl(host_rel_scl), .host_clr_ovf(host_clr_ovf),
        .host_clr_irq(host_clr_irq),
        .buf_q(buf_data), .bf_q(stat_full), .ovf_q(stat_ovf),
        .upd_q(stat_upd_addr), .rw_q(stat_rw), .irq_q(irq),
        .scl_pull(scl_pull), .sda_pull(sda_pull)
    );
endmodule

// File: tb/i2cs_slave_tb_top.sv
// Bench: bit-level bus master plus a host model, table walk for 7-bit
// writes, then directed read, 10-bit and reset checks.
module i2cs_slave_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int Q = 8;

    typedef struct packed {
        logic [7:0] a;
        logic [7:0] d;
        logic       keep;
        logic       aack;
        logic       dack;
        logic [7:0] ebuf;
        logic       eovf;
    } vec_t;

    localparam vec_t VEC [4] = '{
        '{8'hB4, 8'h3C, 1'b0, 1'b1, 1'b1, 8'h3C, 1'b0},
        '{8'hA0, 8'h55, 1'b0, 1'b0, 1'b0, 8'h3C, 1'b0},
        '{8'hB4, 8'hFF, 1'b1, 1'b1, 1'b0, 8'hB4, 1'b1},
        '{8'hB4, 8'h00, 1'b0, 1'b1, 1'b1, 8'h00, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ten = 1'b0;
    logic [7:0] wdata = '0;
    logic wr_addr = 0, wr_buf = 0, rd_buf = 0, rel = 0, clr_ovf = 0, clr_irq = 0;
    logic m_scl_low = 1'b0, m_sda_low = 1'b0;
    logic [7:0] buf_data;
    logic stat_full, stat_ovf, stat_upd, stat_rw, irq, scl_pull, sda_pull;
    logic scl_line, sda_line;
    int n_chk = 0, n_bad = 0;

    assign scl_line = ~(m_scl_low | scl_pull);
    assign sda_line = ~(m_sda_low | sda_pull);

    always #(CLK_PERIOD/2) clk = ~clk;

    i2cs_slave dut_i (
        .clk(clk), .rst_n(rst_n), .ten_bit_en(ten), .host_wdata(wdata),
        .host_wr_addr(wr_addr), .host_wr_buf(wr_buf), .host_rd_buf(rd_buf),
        .host_rel_scl(rel), .host_clr_ovf(clr_ovf), .host_clr_irq(clr_irq),
        .buf_data(buf_data), .stat_full(stat_full), .stat_ovf(stat_ovf),
        .stat_upd_addr(stat_upd), .stat_rw(stat_rw), .irq(irq),
        .scl_in(scl_line), .sda_in(sda_line), .scl_pull(scl_pull), .sda_pull(sda_pull)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Host strobe: 0 addr write, 1 buf write, 2 buf read, 3 release, 4 clr ovf, 5 clr irq
    task automatic host(input int op, input logic [7:0] d);
        @(negedge clk);
        wdata   = d;
        wr_addr = (op == 0);
        wr_buf  = (op == 1);
        rd_buf  = (op == 2);
        rel     = (op == 3);
        clr_ovf = (op == 4);
        clr_irq = (op == 5);
        @(negedge clk);
        {wr_addr, wr_buf, rd_buf, rel, clr_ovf, clr_irq} = '0;
        idle(2);
    endtask

    task automatic scl_up();
        m_scl_low = 1'b0;
        while (!scl_line) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        m_sda_low = ~b;
        idle(Q);
        scl_up();
        idle(2*Q);
        m_scl_low = 1'b1;
        idle(Q);
    endtask

    task automatic recv_bit(output logic b);
        m_sda_low = 1'b0;
        idle(Q);
        scl_up();
        idle(Q);
        b = sda_line;
        idle(Q);
        m_scl_low = 1'b1;
        idle(Q);
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        logic bit_v;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        recv_bit(bit_v);
        ack = ~bit_v;
    endtask

    task automatic recv_byte(output logic [7:0] d, input logic ack);
        for (int i = 7; i >= 0; i--) begin
            logic b;
            recv_bit(b);
            d[i] = b;
        end
        send_bit(~ack);
    endtask

    task automatic bus_start();
        m_sda_low = 1'b0;
        idle(Q);
        scl_up();
        idle(Q);
        m_sda_low = 1'b1;
        idle(Q);
        m_scl_low = 1'b1;
        idle(Q);
    endtask

    task automatic bus_stop();
        m_sda_low = 1'b1;
        idle(Q);
        scl_up();
        idle(Q);
        m_sda_low = 1'b0;
        idle(2*Q);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic ack;
        logic [7:0] d;
        idle(4);
        rst_n = 1'b1;
        idle(2);
        // R1: reset state
        chk("R1 buf", buf_data, 8'h00);
        chk("R1 flags", {stat_full, stat_ovf, stat_upd, stat_rw, irq}, 5'b0);
        chk("R1 pulls", {scl_pull, sda_pull}, 2'b00);

        host(0, 8'hB4);
        for (int i = 0; i < 4; i++) begin
            bus_start();
            send_byte(VEC[i].a, ack);
            chk("R2 address ack", ack, VEC[i].aack);
            chk("R3 irq after address", irq, VEC[i].aack);
            if (VEC[i].aack && !VEC[i].keep) host(2, 8'h00);
            host(5, 8'h00);
            send_byte(VEC[i].d, ack);
            chk("R3/R4 data ack", ack, VEC[i].dack);
            chk("R4 irq on every matched byte", irq, VEC[i].aack);
            bus_stop();
            chk("R3/R4 buffer", buf_data, VEC[i].ebuf);
            chk("R4 overflow", stat_ovf, VEC[i].eovf);
            host(2, 8'h00);
            chk("R5 read clears full", stat_full, 1'b0);
            chk("R5 overflow survives read", stat_ovf, VEC[i].eovf);
            host(4, 8'h00);
            chk("R5 overflow clear", stat_ovf, 1'b0);
            chk("R5 irq held until cleared", irq, VEC[i].aack);
            host(5, 8'h00);
        end

        // R8/R9/R10: 7-bit read of two bytes
        bus_start();
        send_byte(8'hB5, ack);
        chk("R8 read address ack", ack, 1'b1);
        chk("R8 rw status", stat_rw, 1'b1);
        chk("R8 scl held", scl_pull, 1'b1);
        host(2, 8'h00);
        host(5, 8'h00);
        host(1, 8'hC3);
        chk("R8 scl held until release", scl_line, 1'b0);
        host(3, 8'h00);
        recv_byte(d, 1'b1);
        chk("R9 first byte MSB first", d, 8'hC3);
        chk("R9 irq after master ack", irq, 1'b1);
        chk("R9 scl held again", scl_pull, 1'b1);
        host(5, 8'h00);
        host(1, 8'h5E);
        host(3, 8'h00);
        recv_byte(d, 1'b0);
        chk("R9 second byte", d, 8'h5E);
        chk("R10 lines released after nack", {scl_pull, sda_pull}, 2'b00);
        bus_stop();
        host(2, 8'h00);
        host(5, 8'h00);

        // R6/R7: 10-bit write then Repeated Start read, address 0x1A7
        ten = 1'b1;
        host(0, 8'hF2);
        bus_start();
        send_byte(8'hF2, ack);
        chk("R6 high byte ack", ack, 1'b1);
        chk("R6 update flag", stat_upd, 1'b1);
        chk("R6 scl held", scl_pull, 1'b1);
        host(2, 8'h00);
        host(5, 8'h00);
        host(3, 8'h00);
        chk("R8 release ignored during update", scl_pull, 1'b1);
        host(0, 8'hA7);
        chk("R6 address write clears and releases", {stat_upd, scl_pull}, 2'b00);
        send_byte(8'hA7, ack);
        chk("R6 low byte ack", ack, 1'b1);
        chk("R6 update flag second", stat_upd, 1'b1);
        host(2, 8'h00);
        host(5, 8'h00);
        host(0, 8'hF2);
        send_byte(8'h99, ack);
        chk("R6 data ack", ack, 1'b1);
        chk("R6 data buffered", buf_data, 8'h99);
        host(2, 8'h00);
        host(5, 8'h00);
        bus_start();
        send_byte(8'hF3, ack);
        chk("R7 read after restart ack", ack, 1'b1);
        chk("R7 rw status", stat_rw, 1'b1);
        host(2, 8'h00);
        host(5, 8'h00);
        host(1, 8'h6B);
        host(3, 8'h00);
        recv_byte(d, 1'b0);
        chk("R7 transmitted byte", d, 8'h6B);
        bus_stop();
        host(5, 8'h00);
        bus_start();
        send_byte(8'hF3, ack);
        chk("R7 read refused after stop", ack, 1'b0);
        bus_stop();

        // R1: reset mid-state returns everything to zero
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
        idle(2);
        chk("R1 flags after second reset", {stat_full, stat_ovf, stat_upd, stat_rw, irq}, 5'b0);
        finish_run();
    end
endmodule